// File: doc/BRIEF.md
# Column Burst Sequencer with Termination Rules

This block is the column-command side of a synchronous graphics memory. It takes decoded column commands and the programmed mode fields, then produces the per-beat strobes that say when write data is accepted and when read data appears on the bus. It also gives the column address of each beat. For every burst it tracks the burst length, the sequential wrap and the full-page wrap. It handles the three ways a burst can be cut short: an explicit stop, a precharge to the bank of the burst, and a new column command issued on top of it.

Auto-precharge bursts are protected. A command that tries to stop or replace one before its last beat raises a one-cycle illegal flag, and the burst carries on as if no command had come. Read data is delayed by the CAS latency. A write beat is accepted in the cycle after its command and in each cycle after that. When a stop or precharge ends a read, the beats already in the latency pipeline still drain onto the bus.

Top module: `bt_ctrl`

## Requirements
- R1: While reset is held, rd_beat_o, wr_beat_o, wr_blk_o and illegal_o are all low.
- R2: A read issued in cycle t makes beat i visible on rd_beat_o in cycle t+2+i when the CAS latency field equals 2. For any other latency field value it appears in cycle t+3+i.
- R3: Burst length codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Code 7 is full page, and codes 4 to 6 give 1 beat. Beat columns count up from the start column and wrap inside the block of burst-length size that holds the start column.
- R4: A full-page burst steps its column by one modulo 2^COL_W and keeps running until it is stopped or interrupted.
- R5: A write issued in cycle t is accepted in cycles t+1 onward with the same column order as a read. When the single-write mode bit is 1, writes take one beat whatever length is programmed, and reads are not affected.
- R6: A block write (command 3) issued in cycle t gives exactly one cycle of wr_blk_o in cycle t+1, with wr_col_o low three bits forced to zero. wr_beat_o stays low in that cycle.
- R7: A burst stop (command 4) in cycle s on a full-page burst makes cycle s the last engine beat. Read data therefore continues 1 cycle after s at latency 2 and 2 cycles after s at latency 3. No write beat follows s.
- R8: A burst stop while a burst of finite length is still in progress raises illegal_o in the next cycle and leaves the burst unchanged. A burst stop while idle has no effect.
- R9: A precharge (command 5) to the bank of a burst still in progress ends it exactly like a stop. A precharge to any other bank has no effect.
- R10: A read (1), write (2) or block write (3) issued while a burst is in progress ends it after the current beat. The new burst then starts in the next cycle.
- R11: A stop, same-bank precharge or column command issued while an auto-precharge burst is in progress raises illegal_o for one cycle and is ignored.
- R12: A command issued in the last beat cycle of a burst is not an interrupt. It is legal and is accepted even when that burst has auto-precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_i | input | 3 | Command: 0 none, 1 read, 2 write, 3 block write, 4 burst stop, 5 precharge |
| cmd_ap_i | input | 1 | Auto-precharge request with a column command |
| cmd_bank_i | input | BANK_W | Bank of the command |
| cmd_col_i | input | COL_W | Start column of a column command |
| mr_bl_i | input | 3 | Burst length code |
| mr_cl_i | input | CL_W | CAS latency field |
| mr_wsingle_i | input | 1 | Single-beat write mode bit |
| rd_beat_o | output | 1 | Read data valid on the bus this cycle |
| rd_col_o | output | COL_W | Column of the read beat on the bus |
| wr_beat_o | output | 1 | Normal write beat accepted this cycle |
| wr_blk_o | output | 1 | Block write beat accepted this cycle |
| wr_col_o | output | COL_W | Column of the write or block write beat |
| illegal_o | output | 1 | The previous cycle's command was rejected |

## Verification
Two decisions can fall in the same cycle: ending a burst on its own last beat, and judging a command that arrives in that cycle as an interrupt. The bench provokes the pair by issuing a read exactly in the last beat cycle of an auto-precharge burst, then one cycle earlier. The first must start a new burst without a flag. The second must raise the flag and leave the old burst running. A second overlap, read data still draining from the latency pipeline while a stop or interrupt has already redirected the engine, is judged every cycle by the reference model's schedule of future read beats.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_BLKWR = 3'd3,
    CMD_BSTOP = 3'd4,
    CMD_PRECH = 3'd5
  } cmd_e;

  localparam logic [2:0] BL_CODE_FULL = 3'd7;
  localparam int unsigned BLK_ALIGN_BITS = 3;
  localparam int unsigned LEN_LOG2_MAX = 3;
endpackage

// File: rtl/bt_mode_dec.sv
module bt_mode_dec #(
  parameter int CL_W = 3
) (
  input  logic [2:0]      bl_code_i,
  input  logic [CL_W-1:0] cl_code_i,
  input  logic            force_one_i,
  output logic [1:0]      len_log2_o,
  output logic            full_o,
  output logic            cl3_o
);
  import bt_pkg::*;

  logic [1:0] len_raw;

  always_comb begin
    case (bl_code_i)
      3'd1:    len_raw = 2'd1;
      3'd2:    len_raw = 2'd2;
      3'd3:    len_raw = 2'd3;
      default: len_raw = 2'd0;
    endcase
  end

  assign len_log2_o = force_one_i ? 2'd0 : len_raw;
  assign full_o     = (bl_code_i == BL_CODE_FULL) && !force_one_i;
  assign cl3_o      = (cl_code_i != CL_W'(2));
endmodule

// File: rtl/bt_col_step.sv
module bt_col_step #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] inc;

  assign inc = col_i + COL_W'(1);

  always_comb begin
    if (full_i) col_o = inc;
    else        col_o = (col_i & ~mask_i) | (inc & mask_i);
  end
endmodule

// File: rtl/bt_rd_pipe.sv
module bt_rd_pipe #(
  parameter int COL_W = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             cl3_i,
  input  logic [COL_W-1:0] col_i,
  output logic             beat_o,
  output logic [COL_W-1:0] col_o
);
  logic [DEPTH-1:0] v_q, v_d;
  logic [DEPTH-1:0] l_q, l_d;
  logic [COL_W-1:0] c_q [DEPTH];
  logic [COL_W-1:0] c_d [DEPTH];

  assign v_d[0] = beat_i;
  assign l_d[0] = cl3_i;
  assign c_d[0] = col_i;

  for (genvar k = 1; k < DEPTH; k++) begin : g_shift
    assign v_d[k] = v_q[k-1];
    assign l_d[k] = l_q[k-1];
    assign c_d[k] = c_q[k-1];
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[k] <= 1'b0;
        l_q[k] <= 1'b0;
        c_q[k] <= '0;
      end else begin
        v_q[k] <= v_d[k];
        l_q[k] <= l_d[k];
        c_q[k] <= c_d[k];
      end
    end
  end

  always_comb begin
    beat_o = 1'b0;
    col_o  = '0;
    if (v_q[DEPTH-1] && l_q[DEPTH-1]) begin
      beat_o = 1'b1;
      col_o  = c_q[DEPTH-1];
    end else if (v_q[0] && !l_q[0]) begin
      beat_o = 1'b1;
      col_o  = c_q[0];
    end
  end
endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl #(
  parameter int COL_W  = 8,
  parameter int BANK_W = 2,
  parameter int CL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic              cmd_ap_i,
  input  logic [BANK_W-1:0] cmd_bank_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic [2:0]        mr_bl_i,
  input  logic [CL_W-1:0]   mr_cl_i,
  input  logic              mr_wsingle_i,
  output logic              rd_beat_o,
  output logic [COL_W-1:0]  rd_col_o,
  output logic              wr_beat_o,
  output logic              wr_blk_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic              illegal_o
);
  import bt_pkg::*;

  localparam int REM_W    = LEN_LOG2_MAX + 1;
  localparam int PIPE_DEP = 2;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  cmd_e cmd;
  assign cmd = cmd_e'(cmd_i);

  logic is_col_cmd, is_wr_cmd, is_blk_cmd;
  assign is_col_cmd = (cmd == CMD_READ) || (cmd == CMD_WRITE) || (cmd == CMD_BLKWR);
  assign is_blk_cmd = (cmd == CMD_BLKWR);
  assign is_wr_cmd  = (cmd == CMD_WRITE) || is_blk_cmd;

  // engine state
  logic              eng_act_q,  eng_act_d;
  logic [COL_W-1:0]  eng_col_q,  eng_col_d;
  logic [REM_W-1:0]  eng_rem_q,  eng_rem_d;
  logic [COL_W-1:0]  eng_mask_q, eng_mask_d;
  logic              eng_full_q, eng_full_d;
  logic              eng_ap_q,   eng_ap_d;
  logic [BANK_W-1:0] eng_bank_q, eng_bank_d;
  logic              eng_wr_q,   eng_wr_d;
  logic              eng_blk_q,  eng_blk_d;
  logic              eng_cl3_q,  eng_cl3_d;
  logic              ill_q,      ill_d;

  // mode decode for the incoming command
  logic       force_one;
  logic [1:0] new_len_log2;
  logic       new_full, new_cl3;

  assign force_one = is_blk_cmd || (is_wr_cmd && mr_wsingle_i);

  bt_mode_dec #(.CL_W(CL_W)) u_mode (
    .bl_code_i   (mr_bl_i),
    .cl_code_i   (mr_cl_i),
    .force_one_i (force_one),
    .len_log2_o  (new_len_log2),
    .full_o      (new_full),
    .cl3_o       (new_cl3)
  );

  logic [COL_W-1:0] new_mask;
  logic [REM_W-1:0] new_rem;
  logic [COL_W-1:0] new_col;

  assign new_mask = (COL_W'(1) << new_len_log2) - COL_W'(1);
  assign new_rem  = REM_W'(1) << new_len_log2;
  assign new_col  = is_blk_cmd ? {cmd_col_i[COL_W-1:BLK_ALIGN_BITS], {BLK_ALIGN_BITS{1'b0}}}
                               : cmd_col_i;

  logic [COL_W-1:0] step_col;

  bt_col_step #(.COL_W(COL_W)) u_step (
    .col_i  (eng_col_q),
    .mask_i (eng_mask_q),
    .full_i (eng_full_q),
    .col_o  (step_col)
  );

  // a burst is in progress when more beats follow the current one
  logic busy;
  assign busy = eng_act_q && (eng_full_q || (eng_rem_q > REM_W'(1)));

  logic do_start, do_stop;

  always_comb begin
    do_start = 1'b0;
    do_stop  = 1'b0;
    ill_d    = 1'b0;
    if (is_col_cmd) begin
      if (busy && eng_ap_q) ill_d    = 1'b1;
      else                  do_start = 1'b1;
    end else if (cmd == CMD_BSTOP) begin
      if (busy) begin
        if (eng_ap_q || !eng_full_q) ill_d   = 1'b1;
        else                         do_stop = 1'b1;
      end
    end else if (cmd == CMD_PRECH) begin
      if (busy && (cmd_bank_i == eng_bank_q)) begin
        if (eng_ap_q) ill_d   = 1'b1;
        else          do_stop = 1'b1;
      end
    end
  end

  always_comb begin
    eng_act_d  = eng_act_q;
    eng_col_d  = eng_col_q;
    eng_rem_d  = eng_rem_q;
    eng_mask_d = eng_mask_q;
    eng_full_d = eng_full_q;
    eng_ap_d   = eng_ap_q;
    eng_bank_d = eng_bank_q;
    eng_wr_d   = eng_wr_q;
    eng_blk_d  = eng_blk_q;
    eng_cl3_d  = eng_cl3_q;
    if (do_start) begin
      eng_act_d  = 1'b1;
      eng_col_d  = new_col;
      eng_rem_d  = new_rem;
      eng_mask_d = new_mask;
      eng_full_d = new_full;
      eng_ap_d   = cmd_ap_i;
      eng_bank_d = cmd_bank_i;
      eng_wr_d   = is_wr_cmd;
      eng_blk_d  = is_blk_cmd;
      eng_cl3_d  = new_cl3;
    end else if (do_stop) begin
      eng_act_d  = 1'b0;
    end else if (eng_act_q) begin
      if (eng_full_q) begin
        eng_col_d = step_col;
      end else if (eng_rem_q == REM_W'(1)) begin
        eng_act_d = 1'b0;
      end else begin
        eng_rem_d = eng_rem_q - REM_W'(1);
        eng_col_d = step_col;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      eng_act_q  <= 1'b0;
      eng_col_q  <= '0;
      eng_rem_q  <= '0;
      eng_mask_q <= '0;
      eng_full_q <= 1'b0;
      eng_ap_q   <= 1'b0;
      eng_bank_q <= '0;
      eng_wr_q   <= 1'b0;
      eng_blk_q  <= 1'b0;
      eng_cl3_q  <= 1'b0;
      ill_q      <= 1'b0;
    end else begin
      eng_act_q  <= eng_act_d;
      eng_col_q  <= eng_col_d;
      eng_rem_q  <= eng_rem_d;
      eng_mask_q <= eng_mask_d;
      eng_full_q <= eng_full_d;
      eng_ap_q   <= eng_ap_d;
      eng_bank_q <= eng_bank_d;
      eng_wr_q   <= eng_wr_d;
      eng_blk_q  <= eng_blk_d;
      eng_cl3_q  <= eng_cl3_d;
      ill_q      <= ill_d;
    end
  end

  bt_rd_pipe #(.COL_W(COL_W), .DEPTH(PIPE_DEP)) u_rdpipe (
    .clk    (clk),
    .rst_n  (rst_s),
    .beat_i (eng_act_q && !eng_wr_q),
    .cl3_i  (eng_cl3_q),
    .col_i  (eng_col_q),
    .beat_o (rd_beat_o),
    .col_o  (rd_col_o)
  );

  assign wr_beat_o = eng_act_q && eng_wr_q && !eng_blk_q;
  assign wr_blk_o  = eng_act_q && eng_blk_q;
  assign wr_col_o  = eng_col_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/bt_ctrl_chk.sv
module bt_ctrl_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_i,
  input logic             busy,
  input logic             eng_ap,
  input logic             eng_full,
  input logic             wr_beat,
  input logic             wr_blk,
  input logic [COL_W-1:0] wr_col,
  input logic             illegal
);
  logic col_cmd;
  assign col_cmd = (cmd_i == 3'd1) || (cmd_i == 3'd2) || (cmd_i == 3'd3);

  AST_BLK_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blk |-> (wr_col[2:0] == 3'b000)); // R6

  AST_WR_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_beat && wr_blk)); // R6

  AST_AP_COL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_ap && col_cmd) |=> illegal); // R11

  AST_PARTIAL_STOP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_full && cmd_i == 3'd4) |=> illegal); // R8

  AST_FULL_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_full && !eng_ap && cmd_i == 3'd4) |=> (!wr_beat && !wr_blk)); // R7

  AST_ILLEGAL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($past(cmd_i) != 3'd0)); // R11
endmodule

bind bt_ctrl bt_ctrl_chk #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_s),
  .cmd_i    (cmd_i),
  .busy     (busy),
  .eng_ap   (eng_ap_q),
  .eng_full (eng_full_q),
  .wr_beat  (wr_beat_o),
  .wr_blk   (wr_blk_o),
  .wr_col   (wr_col_o),
  .illegal  (illegal_o)
);

// File: tb/bt_ctrl_tb.sv
`timescale 1ns/1ps
module bt_ctrl_tb;
  localparam int COL_W = 8;
  localparam int BANK_W = 2;
  localparam int CL_W = 3;
  localparam int PAGE = 256;

  localparam int C_NOP = 0, C_RD = 1, C_WR = 2, C_BW = 3, C_BS = 4, C_PR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic ap = 1'b0;
  logic [BANK_W-1:0] bank = '0;
  logic [COL_W-1:0] col = '0;
  logic [2:0] bl = 3'd0;
  logic [CL_W-1:0] cl = 3'd2;
  logic wsingle = 1'b0;
  logic rd_beat, wr_beat, wr_blk, illegal;
  logic [COL_W-1:0] rd_col, wr_col;

  always #10 clk = ~clk;

  bt_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W), .CL_W(CL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .cmd_ap_i(ap), .cmd_bank_i(bank),
    .cmd_col_i(col), .mr_bl_i(bl), .mr_cl_i(cl), .mr_wsingle_i(wsingle),
    .rd_beat_o(rd_beat), .rd_col_o(rd_col), .wr_beat_o(wr_beat),
    .wr_blk_o(wr_blk), .wr_col_o(wr_col), .illegal_o(illegal));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req = "R1";

  // reference model
  int m_act = 0, m_col = 0, m_rem = 0, m_len = 1, m_full = 0, m_ap = 0;
  int m_bank = 0, m_wr = 0, m_blk = 0, m_cl3 = 0, m_ill = 0;
  int fut_v[2] = '{0, 0};
  int fut_c[2] = '{0, 0};

  function automatic int bl_len(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic model_step();
    int busy, start, stop, c, blkc, wrc;
    c = int'(cmd);
    fut_v[0] = fut_v[1]; fut_c[0] = fut_c[1]; fut_v[1] = 0;
    if (m_act != 0 && m_wr == 0) begin
      if (m_cl3 != 0) begin fut_v[1] = 1; fut_c[1] = m_col; end
      else begin fut_v[0] = 1; fut_c[0] = m_col; end
    end
    busy = (m_act != 0) && (m_full != 0 || m_rem > 1);
    start = 0; stop = 0; m_ill = 0;
    if (c == C_RD || c == C_WR || c == C_BW) begin
      if (busy != 0 && m_ap != 0) m_ill = 1; else start = 1;
    end else if (c == C_BS && busy != 0) begin
      if (m_ap != 0 || m_full == 0) m_ill = 1; else stop = 1;
    end else if (c == C_PR && busy != 0 && int'(bank) == m_bank) begin
      if (m_ap != 0) m_ill = 1; else stop = 1;
    end
    if (start != 0) begin
      blkc = (c == C_BW);
      wrc = (c != C_RD);
      m_act = 1; m_ap = ap; m_bank = int'(bank); m_wr = wrc; m_blk = blkc;
      m_cl3 = (int'(cl) != 2);
      if (blkc != 0 || (wrc != 0 && wsingle)) begin m_len = 1; m_full = 0; end
      else begin m_full = (bl == 3'd7); m_len = bl_len(int'(bl)); end
      m_rem = m_len;
      m_col = blkc ? (int'(col) / 8) * 8 : int'(col);
    end else if (stop != 0) begin
      m_act = 0;
    end else if (m_act != 0) begin
      if (m_full != 0) m_col = (m_col + 1) % PAGE;
      else if (m_rem == 1) m_act = 0;
      else begin
        m_rem = m_rem - 1;
        m_col = (m_col - (m_col % m_len)) + ((m_col % m_len) + 1) % m_len;
      end
    end
  endtask

  task automatic fail(string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
  endtask

  task automatic compare();
    int ew, eb;
    ew = (m_act != 0 && m_wr != 0 && m_blk == 0);
    eb = (m_act != 0 && m_blk != 0);
    checks++;
    if (int'(rd_beat) != fut_v[0]) fail("rd_beat", int'(rd_beat), fut_v[0]);
    else if (fut_v[0] != 0 && int'(rd_col) != fut_c[0]) fail("rd_col", int'(rd_col), fut_c[0]);
    else if (int'(wr_beat) != ew) fail("wr_beat", int'(wr_beat), ew);
    else if (int'(wr_blk) != eb) fail("wr_blk", int'(wr_blk), eb);
    else if ((ew != 0 || eb != 0) && int'(wr_col) != m_col) fail("wr_col", int'(wr_col), m_col);
    else if (int'(illegal) != m_ill) fail("illegal", int'(illegal), m_ill);
  endtask

  task automatic cyc(int c, int a = 0, int b = 0, int cc = 0);
    @(negedge clk);
    compare();
    cmd = 3'(c); ap = a[0]; bank = BANK_W'(b); col = COL_W'(cc);
    @(posedge clk);
    #1;
    model_step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(C_NOP);
  endtask

  initial begin
    // R1: outputs quiet while reset is held
    repeat (3) @(negedge clk);
    checks++;
    if (rd_beat || wr_beat || wr_blk || illegal)
      fail("reset outputs", int'({rd_beat, wr_beat, wr_blk, illegal}), 0);
    rst_n = 1'b1;
    idle(4);

    req = "R2"; bl = 3'd2; cl = 3'd2;
    cyc(C_RD, 0, 0, 8'h0E); idle(7);
    cl = 3'd3; cyc(C_RD, 0, 1, 8'h21); idle(7);
    cl = 3'd0; bl = 3'd1; cyc(C_RD, 0, 0, 8'h33); idle(6);

    req = "R3"; cl = 3'd2;
    bl = 3'd3; cyc(C_RD, 0, 0, 8'h45); idle(10);
    bl = 3'd0; cyc(C_RD, 0, 0, 8'h47); idle(4);
    bl = 3'd5; cyc(C_RD, 0, 0, 8'h49); idle(4);
    bl = 3'd2; cyc(C_RD, 0, 2, 8'h17); idle(6);

    req = "R4"; bl = 3'd7;
    cyc(C_RD, 0, 0, 8'hFD); idle(6);
    req = "R7"; cyc(C_BS); idle(5);

    req = "R5"; bl = 3'd2;
    cyc(C_WR, 0, 0, 8'h03); idle(6);
    wsingle = 1'b1; bl = 3'd3; cyc(C_WR, 0, 0, 8'h55); idle(4);
    bl = 3'd2; cyc(C_RD, 0, 0, 8'h56); idle(6);
    wsingle = 1'b0;

    req = "R6"; cyc(C_BW, 0, 1, 8'h2D); idle(4);

    req = "R7"; bl = 3'd7;
    cyc(C_WR, 0, 0, 8'h10); idle(3); cyc(C_BS); idle(4);
    cl = 3'd3; cyc(C_RD, 0, 0, 8'h20); idle(3); cyc(C_BS); idle(6);
    cl = 3'd2;

    req = "R8"; bl = 3'd3;
    cyc(C_RD, 0, 0, 8'h60); idle(2); cyc(C_BS); idle(8);
    cyc(C_BS); idle(3);

    req = "R9";
    cyc(C_WR, 0, 1, 8'h70); idle(1); cyc(C_PR, 0, 2); idle(1); cyc(C_PR, 0, 1); idle(4);
    cl = 3'd3; cyc(C_RD, 0, 3, 8'h78); idle(2); cyc(C_PR, 0, 3); idle(6);
    cl = 3'd2;

    req = "R10";
    cyc(C_RD, 0, 0, 8'h80); idle(2); cyc(C_WR, 0, 0, 8'h90); idle(2);
    bl = 3'd2; cyc(C_RD, 0, 0, 8'hA1); idle(10);
    bl = 3'd3; cyc(C_WR, 0, 1, 8'hB0); idle(1); cyc(C_BW, 0, 1, 8'hC5); idle(4);

    req = "R11";
    cyc(C_RD, 1, 2, 8'hD0); idle(1);
    cyc(C_RD, 0, 0, 8'h11); cyc(C_PR, 0, 2); cyc(C_BS); cyc(C_WR, 0, 0, 8'h12);
    idle(8);

    req = "R12"; bl = 3'd2;
    cyc(C_RD, 1, 0, 8'hE0); idle(3); cyc(C_RD, 1, 0, 8'hE8); idle(2);
    cyc(C_RD, 0, 0, 8'hF0); idle(8);

    @(negedge clk); compare();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule